// File: doc/BRIEF.md
# Sleep and Watchdog Status Controller

This block carries out the power-down instruction of a small 8-bit processor core. It also owns the watchdog timer and the two status flags that record why the core last stopped or restarted. A two-bit phase counter splits each instruction cycle into four clocks, Q1 to Q4.

- In Q1 the block samples the instruction word and decodes it.
- In Q3 the decoded operation takes effect.
- In Q4 a power-down instruction raises a clock-stop request.

The watchdog counts ticks of a separate always-on enable, through a counter followed by a postscaler. It keeps counting while the core is stopped.

A stopped core restarts on one of two events. A watchdog overflow restarts it and records that the timer caused the wake. An external wake input also restarts it and leaves the time-out flag as it was. If the watchdog overflows while the core is running, the block instead issues a one-cycle reset request. The neighbouring clock logic uses the clock-stop request and the wake pulse. The core's status logic reads the two flags.

Top module: `sleep_wdt_ctrl`

## Requirements
- R1: After reset, to_flag=1, pd_flag=1, clk_stop_req=0, wake_pulse=0, wake_by_wdt=0, wdt_reset_req=0 and qphase=0 (Q1). qphase counts 0,1,2,3 for Q1..Q4.
- R2: When instr_valid is high in Q1 with instr_word=16'h0003, the clock edge that ends Q3 sets to_flag to 1, clears pd_flag to 0, and clears both the watchdog counter and its postscaler.
- R3: For that same instruction, clk_stop_req rises on the edge that ends Q4 and stays high until a wake. While clk_stop_req is high, qphase holds at 0.
- R4: The watchdog overflows on the 2^(CNT_W+POST_W)-th wdt_tick after its last clear (64 with the defaults) and not earlier.
- R5: A watchdog overflow while clk_stop_req is high drops clk_stop_req, clears to_flag, sets wake_by_wdt and asserts no reset request.
- R6: A high wake_ext while clk_stop_req is high drops clk_stop_req, leaves to_flag unchanged and clears wake_by_wdt. Every wake produces wake_pulse for exactly one cycle. wake_ext has no effect while clk_stop_req is low.
- R7: After a wake, pd_flag stays 0 until the clear-watchdog opcode 16'h0004 executes. That opcode sets to_flag and pd_flag to 1 at the end of Q3 and clears the watchdog.
- R8: A watchdog overflow while clk_stop_req is low pulses wdt_reset_req for one cycle and clears to_flag.
- R9: The following change no flag and raise no clock-stop request: an opcode other than the two above, and any instruction presented while clk_stop_req is high.
- R10: When an overflow and wake_ext coincide during sleep, the watchdog is recorded as the cause: to_flag=0 and wake_by_wdt=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| instr_valid | input | 1 | Instruction word is valid (sampled in Q1) |
| instr_word | input | 16 | Instruction word |
| wdt_tick | input | 1 | Always-on watchdog count enable |
| wake_ext | input | 1 | External wake event |
| qphase | output | 2 | Current instruction phase, 0..3 = Q1..Q4 |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| clk_stop_req | output | 1 | Request to stop the core oscillator |
| wake_pulse | output | 1 | One-cycle pulse on leaving sleep |
| wake_by_wdt | output | 1 | Last wake came from the watchdog |
| wdt_reset_req | output | 1 | One-cycle reset request on awake time-out |

## Verification
The hardest case to reach is a wake in which the postscaler matters. A design that clears only the low counter on power-down would still wake, just too early. To expose this, the stimulus first advances the watchdog by 40 ticks so that the postscaler holds a non-zero value. It then executes the power-down instruction and checks that the core is still stopped after 63 further ticks, and that the 64th tick wakes it. The coincident wake case is built the same way. The bench counts the core to one tick short of overflow during sleep, then raises the final tick and the external wake in the same cycle.

// File: rtl/sleep_wdt_pkg.sv
package sleep_wdt_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_t;

  typedef struct packed {
    logic pwrdn;
    logic wdclr;
  } op_t;
endpackage

// File: rtl/sleep_wdt_phase.sv
module sleep_wdt_phase
  import sleep_wdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hold,
  output phase_t phase
);
  // Four-phase sequencer; parked on Q1 while the core clock is stopped.
  always_ff @(posedge clk) begin
    if (rst)       phase <= PH_Q1;
    else if (hold) phase <= PH_Q1;
    else           phase <= phase_t'(phase + 2'd1);
  end
endmodule

// File: rtl/sleep_wdt_decode.sv
module sleep_wdt_decode
  import sleep_wdt_pkg::*;
#(
  parameter int          IW        = 16,
  parameter logic [IW-1:0] PWRDN_OPC = 16'h0003,
  parameter logic [IW-1:0] WDCLR_OPC = 16'h0004
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase,
  input  logic          hold,
  input  logic          valid,
  input  logic [IW-1:0] word,
  output op_t           op
);
  op_t dec;

  always_comb begin
    dec       = '0;
    dec.pwrdn = valid && (word == PWRDN_OPC);
    dec.wdclr = valid && (word == WDCLR_OPC);
  end

  // Latch in Q1, retire in Q4.
  always_ff @(posedge clk) begin
    if (rst)                           op <= '0;
    else if (phase == PH_Q1 && !hold)  op <= dec;
    else if (phase == PH_Q4)           op <= '0;
  end
endmodule

// File: rtl/sleep_wdt_timer.sv
module sleep_wdt_timer #(
  parameter int CNT_W  = 4,
  parameter int POST_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic ovf
);
  logic [CNT_W-1:0] cnt;
  logic             post_full;
  logic             cnt_wrap;

  assign cnt_wrap = tick && (&cnt);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  generate
    if (POST_W > 0) begin : g_post
      logic [POST_W-1:0] post;
      always_ff @(posedge clk) begin
        if (rst || clr)    post <= '0;
        else if (cnt_wrap) post <= post + 1'b1;
      end
      assign post_full = &post;
    end else begin : g_nopost
      assign post_full = 1'b1;
    end
  endgenerate

  assign ovf = cnt_wrap && post_full && !clr;
endmodule

// File: rtl/sleep_wdt_ctrl.sv
module sleep_wdt_ctrl
  import sleep_wdt_pkg::*;
#(
  parameter int          CNT_W     = 4,
  parameter int          POST_W    = 2,
  parameter int          IW        = 16,
  parameter logic [IW-1:0] PWRDN_OPC = 16'h0003,
  parameter logic [IW-1:0] WDCLR_OPC = 16'h0004
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr_word,
  input  logic          wdt_tick,
  input  logic          wake_ext,
  output logic [1:0]    qphase,
  output logic          to_flag,
  output logic          pd_flag,
  output logic          clk_stop_req,
  output logic          wake_pulse,
  output logic          wake_by_wdt,
  output logic          wdt_reset_req
);
  phase_t phase;
  op_t    op;
  logic   wdt_ovf;
  logic   do_pwrdn;
  logic   do_wdclr;

  sleep_wdt_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .hold  (clk_stop_req),
    .phase (phase)
  );

  sleep_wdt_decode #(
    .IW        (IW),
    .PWRDN_OPC (PWRDN_OPC),
    .WDCLR_OPC (WDCLR_OPC)
  ) u_dec (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .hold  (clk_stop_req),
    .valid (instr_valid),
    .word  (instr_word),
    .op    (op)
  );

  assign do_pwrdn = op.pwrdn && (phase == PH_Q3);
  assign do_wdclr = op.wdclr && (phase == PH_Q3);

  sleep_wdt_timer #(
    .CNT_W  (CNT_W),
    .POST_W (POST_W)
  ) u_wdt (
    .clk  (clk),
    .rst  (rst),
    .tick (wdt_tick),
    .clr  (do_pwrdn || do_wdclr),
    .ovf  (wdt_ovf)
  );

  assign qphase = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      to_flag       <= 1'b1;
      pd_flag       <= 1'b1;
      clk_stop_req  <= 1'b0;
      wake_pulse    <= 1'b0;
      wake_by_wdt   <= 1'b0;
      wdt_reset_req <= 1'b0;
    end else begin
      wake_pulse    <= 1'b0;
      wdt_reset_req <= 1'b0;
      if (clk_stop_req) begin
        if (wdt_ovf) begin
          clk_stop_req <= 1'b0;
          to_flag      <= 1'b0;
          wake_by_wdt  <= 1'b1;
          wake_pulse   <= 1'b1;
        end else if (wake_ext) begin
          clk_stop_req <= 1'b0;
          wake_by_wdt  <= 1'b0;
          wake_pulse   <= 1'b1;
        end
      end else begin
        if (do_wdclr) begin
          to_flag <= 1'b1;
          pd_flag <= 1'b1;
        end else if (do_pwrdn) begin
          to_flag <= 1'b1;
          pd_flag <= 1'b0;
        end else if (wdt_ovf) begin
          to_flag       <= 1'b0;
          wdt_reset_req <= 1'b1;
        end
        if (op.pwrdn && phase == PH_Q4) clk_stop_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sleep_wdt_checker.sv
module sleep_wdt_checker (
  input logic       clk,
  input logic       rst,
  input logic       wake_ext,
  input logic       wdt_ovf,
  input logic [1:0] qphase,
  input logic       to_flag,
  input logic       pd_flag,
  input logic       clk_stop_req,
  input logic       wake_pulse,
  input logic       wake_by_wdt,
  input logic       wdt_reset_req
);
  p_phase_park_r3: assert property (@(posedge clk) disable iff (rst)
    clk_stop_req |-> qphase == 2'd0);

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
    clk_stop_req && !wdt_ovf && !wake_ext |=> clk_stop_req);

  p_wdt_wake_r5: assert property (@(posedge clk) disable iff (rst)
    clk_stop_req && wdt_ovf |=> !clk_stop_req && !to_flag && wake_by_wdt && !wdt_reset_req);

  p_ext_wake_r6: assert property (@(posedge clk) disable iff (rst)
    clk_stop_req && wake_ext && !wdt_ovf |=> !clk_stop_req && $stable(to_flag) && !wake_by_wdt);

  p_wake_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $fell(clk_stop_req));

  p_pd_set_q3_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_flag) |-> $past(qphase) == 2'd2);

  p_rreq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |=> !wdt_reset_req);

  p_rreq_awake_r8: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |-> $past(!clk_stop_req) && !to_flag);
endmodule

bind sleep_wdt_ctrl sleep_wdt_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .wake_ext      (wake_ext),
  .wdt_ovf       (wdt_ovf),
  .qphase        (qphase),
  .to_flag       (to_flag),
  .pd_flag       (pd_flag),
  .clk_stop_req  (clk_stop_req),
  .wake_pulse    (wake_pulse),
  .wake_by_wdt   (wake_by_wdt),
  .wdt_reset_req (wdt_reset_req)
);

// File: tb/sleep_wdt_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_wdt_ctrl_bench;
  localparam logic [15:0] OPC_PWRDN = 16'h0003;
  localparam logic [15:0] OPC_WDCLR = 16'h0004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic        wdt_tick = 1'b0;
  logic        wake_ext = 1'b0;
  logic [1:0]  qphase;
  logic        to_flag, pd_flag, clk_stop_req, wake_pulse, wake_by_wdt, wdt_reset_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    string      tag;
    logic [5:0] exp;  // {to, pd, stop, wake_pulse, by_wdt, reset_req}
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  sleep_wdt_ctrl u_sleep_wdt_ctrl (
    .clk           (clk),
    .rst           (rst),
    .instr_valid   (instr_valid),
    .instr_word    (instr_word),
    .wdt_tick      (wdt_tick),
    .wake_ext      (wake_ext),
    .qphase        (qphase),
    .to_flag       (to_flag),
    .pd_flag       (pd_flag),
    .clk_stop_req  (clk_stop_req),
    .wake_pulse    (wake_pulse),
    .wake_by_wdt   (wake_by_wdt),
    .wdt_reset_req (wdt_reset_req)
  );

  task automatic expect_out(input string tag, input logic [5:0] e);
    item_t it;
    it.tag = tag;
    it.exp = e;
    sb.push_back(it);
  endtask

  task automatic chk_phase(input string tag, input logic [1:0] e);
    n_checks++;
    if (qphase !== e) begin
      n_fail++;
      $display("FAIL %s qphase actual=%0d expected=%0d", tag, qphase, e);
    end
  endtask

  // Monitor: compares queued expectations just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [5:0] act;
        it  = sb.pop_front();
        act = {to_flag, pd_flag, clk_stop_req, wake_pulse, wake_by_wdt, wdt_reset_req};
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s {to,pd,stop,wake,bywdt,rreq} actual=%b expected=%b",
                   it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      wdt_tick = 1'b1;
      @(negedge clk);
      wdt_tick = 1'b0;
    end
  endtask

  // Present an opcode in Q1; returns after the edge that ends Q3.
  task automatic exec(input logic [15:0] w);
    while (!(qphase == 2'd0 && !clk_stop_req)) @(negedge clk);
    instr_word  = w;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    step(2);
  endtask

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1'b1;
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1: reset state
    expect_out("R1 reset", 6'b110000);
    chk_phase("R1 reset", 2'd0);
    step(1);

    // R9: unrelated opcode has no effect
    exec(16'h0013);
    expect_out("R9 other opcode", 6'b110000);
    step(1);
    expect_out("R9 other opcode Q4", 6'b110000);

    // R6: external wake while awake ignored
    wake_ext = 1'b1;
    step(1);
    wake_ext = 1'b0;
    expect_out("R6 wake_ext awake ignored", 6'b110000);

    // R2/R3/R4/R5: advance postscaler, power down, wake by watchdog
    tick(40);
    exec(OPC_PWRDN);
    expect_out("R2 flags at Q3", 6'b100000);
    step(1);
    expect_out("R3 stop after Q4", 6'b101000);
    tick(63);
    expect_out("R4 no overflow at 63 ticks", 6'b101000);
    chk_phase("R3 phase parked", 2'd0);
    tick(1);
    expect_out("R5 watchdog wake", 6'b000110);
    step(1);
    expect_out("R6 wake pulse one cycle", 6'b000010);

    // R9/R6/R7: instruction while asleep ignored, external wake
    exec(OPC_PWRDN);
    expect_out("R2 second power-down", 6'b100010);
    step(1);
    expect_out("R3 asleep again", 6'b101010);
    instr_word  = OPC_WDCLR;
    instr_valid = 1'b1;
    step(4);
    instr_valid = 1'b0;
    expect_out("R9 instr while asleep", 6'b101010);
    chk_phase("R3 phase parked with valid", 2'd0);
    wake_ext = 1'b1;
    step(1);
    wake_ext = 1'b0;
    expect_out("R6 external wake", 6'b100100);
    step(1);
    expect_out("R7 pd held after wake", 6'b100000);

    // R7/R8: clear-watchdog then awake time-out
    exec(OPC_WDCLR);
    expect_out("R7 clear-watchdog", 6'b110000);
    step(1);
    tick(63);
    expect_out("R4 awake 63 ticks", 6'b110000);
    tick(1);
    expect_out("R8 awake reset request", 6'b010001);
    step(1);
    expect_out("R8 reset request one cycle", 6'b010000);

    // R10: coincident overflow and external wake
    exec(OPC_PWRDN);
    step(1);
    expect_out("R3 asleep for R10", 6'b101000);
    tick(63);
    wdt_tick = 1'b1;
    wake_ext = 1'b1;
    step(1);
    wdt_tick = 1'b0;
    wake_ext = 1'b0;
    expect_out("R10 watchdog wins", 6'b000110);
    step(2);
    done = 1'b1;
  end

  initial begin
    wait (done);
    step(1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule